// File: doc/BRIEF.md
# Selectable Burst Address Sequencer

This block produces the address sequence for a short burst into a synchronous memory core. When either of two active-low address strobes is sampled low on a rising clock edge, the block captures a full start address. On each later edge where the active-low advance input is low and no strobe is present, the block moves to the next beat. The low-order bits of the output address then step through a four-beat pattern, while the upper bits keep the value captured at the strobe.

A mode input chooses the pattern. In interleaved order the low bits are the start bits XOR-ed with the beat number. In linear order they are the start bits plus the beat number, wrapping within the group of four. The output drives the address port of a memory core directly. A beat number and a last-beat flag come out beside the address so that surrounding control logic can see where the burst stands. The beat counter width is a parameter; its default of two bits gives four beats.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted (rst_n low) and on the first cycle after it, addr_out is all zeros, beat is 0 and beat_last is 0.
- R2: A rising edge with strb_a_n or strb_b_n low loads addr_in. From the next cycle addr_out equals the loaded address and beat is 0.
- R3: A strobe overrides any burst in progress, even when adv_n is low on the same edge. The new address is loaded and beat returns to 0.
- R4: On an edge with no strobe and adv_n low, beat increases by one, modulo 4 for the default two-bit counter.
- R5: On an edge with no strobe and adv_n high, addr_out and beat are unchanged.
- R6: With order_lin = 0 (interleaved), addr_out[1:0] equals start[1:0] XOR beat, where start is the address last loaded.
- R7: With order_lin = 1 (linear), addr_out[1:0] equals (start[1:0] + beat) modulo 4.
- R8: addr_out bits above the beat field always equal the upper bits of the address last loaded.
- R9: beat_last is 1 exactly when beat is 3, which is the fourth beat.
- R10: Advancing from the fourth beat returns beat to 0 and addr_out to the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strb_a_n | input | 1 | First address strobe, active low |
| strb_b_n | input | 1 | Second address strobe, active low |
| adv_n | input | 1 | Advance to next beat, active low |
| order_lin | input | 1 | Burst order: 0 interleaved, 1 linear |
| addr_in | input | AW | Start address captured on a strobe |
| addr_out | output | AW | Current burst address |
| beat | output | BW | Beats taken since the load |
| beat_last | output | 1 | High on the final beat |

## Verification
The bench sweeps every start offset in both orders. It compares each beat against a sequence computed arithmetically, which exposes an adder used in place of XOR or a carry that leaks into the upper address bits. It advances past the fourth beat to check that the sequence wraps to the start and does not continue counting. It also inserts hold cycles to catch a counter that steps without adv_n. It fires a strobe in the same cycle as an advance to catch a design that lets the advance win. Both strobes are used to load, so a design that decodes only one of them fails.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

   typedef enum logic {
      ORD_XOR  = 1'b0,
      ORD_WRAP = 1'b1
   } order_e;

   function automatic order_e to_order(input logic sel);
      return sel ? ORD_WRAP : ORD_XOR;
   endfunction

endpackage

// File: rtl/bseq_start_reg.sv
module bseq_start_reg #(
   parameter int AW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] d,
   output logic [AW-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= d;
      end
   end

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
   parameter int BW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   output logic [BW-1:0] cnt,
   output logic          last
);

   localparam logic [BW-1:0] CNT_MAX = {BW{1'b1}};
   localparam logic [BW-1:0] CNT_ONE = {{(BW-1){1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= cnt + CNT_ONE;
      end
   end

   assign last = (cnt == CNT_MAX);

endmodule

// File: rtl/bseq_offset_map.sv
module bseq_offset_map
   import bseq_pkg::*;
#(
   parameter int BW = 2
) (
   input  logic [BW-1:0] start,
   input  logic [BW-1:0] cnt,
   input  order_e        order,
   output logic [BW-1:0] off
);

   logic [BW:0]   carry;
   logic [BW-1:0] sum_bits;
   logic [BW-1:0] xor_bits;

   assign carry[0] = 1'b0;

   for (genvar i = 0; i < BW; i++) begin : g_bit
      assign xor_bits[i]  = start[i] ^ cnt[i];
      assign sum_bits[i]  = xor_bits[i] ^ carry[i];
      assign carry[i+1]   = (start[i] & cnt[i]) | (carry[i] & xor_bits[i]);
      assign off[i]       = (order == ORD_WRAP) ? sum_bits[i] : xor_bits[i];
   end

   logic unused_carry;
   assign unused_carry = carry[BW];

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import bseq_pkg::*;
#(
   parameter int AW = 18,
   parameter int BW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strb_a_n,
   input  logic          strb_b_n,
   input  logic          adv_n,
   input  logic          order_lin,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] addr_out,
   output logic [BW-1:0] beat,
   output logic          beat_last
);

   localparam int UW = AW - BW;

   if (BW < 1) begin : g_bad_bw
      $error("burst_addr_seq: BW must be at least 1");
   end
   if (AW <= BW) begin : g_bad_aw
      $error("burst_addr_seq: AW must exceed BW");
   end

   logic          load;
   logic          step;
   logic [AW-1:0] start_q;
   logic [BW-1:0] low_off;

   assign load = !strb_a_n || !strb_b_n;
   assign step = !adv_n && !load;

   bseq_start_reg #(.AW(AW)) u_start (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .d     (addr_in),
      .q     (start_q)
   );

   bseq_beat_ctr #(.BW(BW)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .step  (step),
      .cnt   (beat),
      .last  (beat_last)
   );

   bseq_offset_map #(.BW(BW)) u_map (
      .start (start_q[BW-1:0]),
      .cnt   (beat),
      .order (to_order(order_lin)),
      .off   (low_off)
   );

   assign addr_out = {start_q[AW-1 -: UW], low_off};

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
   parameter int AW = 18,
   parameter int BW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          strb_a_n,
   input logic          strb_b_n,
   input logic          adv_n,
   input logic          order_lin,
   input logic [AW-1:0] addr_in,
   input logic [AW-1:0] addr_out,
   input logic [BW-1:0] beat,
   input logic          beat_last
);

   logic          ld;
   logic [AW-1:0] shadow;

   assign ld = !strb_a_n || !strb_b_n;

   always_ff @(posedge clk) begin
      if (!rst_n) shadow <= '0;
      else if (ld) shadow <= addr_in;
   end

   AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (addr_out == $past(addr_in)) && (beat == '0)) else $error("load"); // R2
   AST_STROBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !adv_n) |=> (beat == '0)) else $error("priority"); // R3
   AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !adv_n) |=> (beat == $past(beat) + 1'b1)) else $error("step"); // R4
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && adv_n) |=> ($stable(addr_out) && $stable(beat))) else $error("hold"); // R5
   AST_XOR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      !order_lin |-> (addr_out[BW-1:0] == (shadow[BW-1:0] ^ beat))) else $error("xor"); // R6
   AST_WRAP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      order_lin |-> (addr_out[BW-1:0] == BW'(shadow[BW-1:0] + beat))) else $error("lin"); // R7
   AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      addr_out[AW-1:BW] == shadow[AW-1:BW]) else $error("upper"); // R8
   AST_LAST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_last && !ld && !adv_n) |=> (beat == '0) && (addr_out == shadow)) else $error("wrap"); // R10

endmodule

bind burst_addr_seq bseq_chk #(.AW(AW), .BW(BW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .strb_a_n  (strb_a_n),
   .strb_b_n  (strb_b_n),
   .adv_n     (adv_n),
   .order_lin (order_lin),
   .addr_in   (addr_in),
   .addr_out  (addr_out),
   .beat      (beat),
   .beat_last (beat_last)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 10;
   localparam int BW = 2;
   localparam int UW = AW - BW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          strb_a_n, strb_b_n, adv_n, order_lin;
   logic [AW-1:0] addr_in;
   logic [AW-1:0] addr_out;
   logic [BW-1:0] beat;
   logic          beat_last;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_addr_seq #(.AW(AW), .BW(BW)) u_burst_addr_seq (
      .clk(clk), .rst_n(rst_n), .strb_a_n(strb_a_n), .strb_b_n(strb_b_n),
      .adv_n(adv_n), .order_lin(order_lin), .addr_in(addr_in),
      .addr_out(addr_out), .beat(beat), .beat_last(beat_last)
   );

   task automatic check(input string req, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   function automatic int ref_low(input bit lin, input int s, input int k);
      return lin ? ((s + k) % 4) : (s ^ k);
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; strb_a_n = 1'b1; strb_b_n = 1'b1; adv_n = 1'b1;
      order_lin = 1'b0; addr_in = '0;
      tick(); tick();
      check("R1 addr", int'(addr_out), 0);
      check("R1 beat", int'(beat), 0);
      check("R1 last", int'(beat_last), 0);
      rst_n = 1'b1;
      tick();
      check("R1 after release", int'(addr_out), 0);

      for (int lin = 0; lin < 2; lin++) begin
         for (int s = 0; s < 4; s++) begin
            for (int h = 0; h < 2; h++) begin
               int up;
               up = h ? 8'hC5 : 8'h3A;
               order_lin = lin[0];
               addr_in = AW'((up << BW) | s);
               adv_n = 1'b1;
               if (s[0]) strb_b_n = 1'b0; else strb_a_n = 1'b0;
               tick();
               strb_a_n = 1'b1; strb_b_n = 1'b1;
               addr_in = '1;
               check("R2 load addr", int'(addr_out), (up << BW) | s);
               check("R2 load beat", int'(beat), 0);
               for (int k = 1; k <= 5; k++) begin
                  adv_n = 1'b0;
                  tick();
                  check(lin ? "R7 linear low" : "R6 interleave low",
                        int'(addr_out[BW-1:0]), ref_low(lin[0], s, k % 4));
                  check("R8 upper", int'(addr_out[AW-1:BW]), up);
                  check("R4 beat", int'(beat), k % 4);
                  check("R9 last", int'(beat_last), (k % 4 == 3) ? 1 : 0);
                  if (k == 4) check("R10 wrap", int'(addr_out), (up << BW) | s);
                  if (k == 2) begin
                     adv_n = 1'b1;
                     tick(); tick();
                     check("R5 hold addr", int'(addr_out[BW-1:0]), ref_low(lin[0], s, 2));
                     check("R5 hold beat", int'(beat), 2);
                  end
               end
               adv_n = 1'b1;
            end
         end
      end

      // R3: strobe together with advance in the middle of a burst
      order_lin = 1'b1;
      addr_in = AW'(10'h2B1);
      strb_a_n = 1'b0; tick(); strb_a_n = 1'b1;
      adv_n = 1'b0; tick();
      addr_in = AW'(10'h0F2);
      strb_b_n = 1'b0; tick(); strb_b_n = 1'b1;
      adv_n = 1'b1;
      check("R3 override addr", int'(addr_out), 10'h0F2);
      check("R3 override beat", int'(beat), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule